// File: doc/BRIEF.md
# Converter Clock Change Sequencer

This block changes the oversampling ratio and converter clock divider of an audio output path without passing glitches to the converter. Software asks for a change by presenting a divider value and an oversampling value with a one-cycle start pulse. The block then silences the sample stream, forcing all-zero data. It counts a fixed number of sample periods on a sample-rate strobe and then switches the applied settings. It counts the same number of periods again and only then lets the incoming samples through once more.

The applied settings drive the clock generator and the converter, and they move only in the middle of the silent window. A busy flag covers the whole sequence, and a one-cycle done flag marks its last cycle. Start pulses that arrive while a sequence is running are dropped.

Top module: `dac_clkswitch_seq`

## Requirements
- R1: After reset the block is idle. busy, done and muted are 0, cur_div equals DEF_DIV (default 1) and cur_osr equals DEF_OSR (default 2).
- R2: While muted is 1, smp_out is all zeros whatever smp_in carries. While muted is 0, smp_out equals smp_in in the same cycle.
- R3: A start pulse while idle sets busy and muted from the next cycle, and req_div and req_osr are captured at that clock edge.
- R4: cur_div and cur_osr keep their old values until SETTLE_TICKS (default 300) fs_tick pulses have been counted after mute. They take the captured request one cycle after the clock edge that counts the last of those pulses, and they change only while muted is 1.
- R5: After the new settings are applied, SETTLE_TICKS more fs_tick pulses are counted. done is 1 for the single cycle after the edge that counts the last of them, and muted and busy fall together on the following edge.
- R6: An fs_tick pulse that falls on the cycle in which the settings are applied is not counted in either wait. With fs_tick held high, busy is therefore high for 2*SETTLE_TICKS+2 cycles after the start edge.
- R7: A start pulse while busy is 1, including the done cycle, is ignored. Changes on req_div and req_osr after capture have no effect on the applied values.
- R8: fs_tick pulses while idle change nothing. busy and muted stay 0 and the applied settings hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| smp_in | input | CHANNELS*CH_W (32) | Sample data from the audio path |
| start | input | 1 | Request pulse for a settings change |
| req_div | input | DIV_W (4) | Requested converter clock divider |
| req_osr | input | OSR_W (3) | Requested oversampling ratio code |
| busy | output | 1 | A change sequence is in progress |
| done | output | 1 | Last cycle of a sequence |
| muted | output | 1 | Output data forced to zero |
| smp_out | output | CHANNELS*CH_W (32) | Data presented to the converter |
| cur_div | output | DIV_W (4) | Applied converter clock divider |
| cur_osr | output | OSR_W (3) | Applied oversampling ratio code |

## Verification
Two events can land on the same cycle, and each has a defined outcome. The first is a sample strobe on the cycle the settings are applied. A test holds fs_tick high through a whole sequence, which forces this overlap, and the busy length must then come out at exactly 602 cycles. The second is a new start on the done cycle, which is provoked by raising start while done is seen high. That start must be dropped: busy stays low afterwards and the applied settings keep the values of the first request.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUTE_WAIT,
    ST_APPLY,
    ST_SETTLE_WAIT,
    ST_RELEASE
  } seq_state_t;
endpackage

// File: rtl/dcs_tick_counter.sv
module dcs_tick_counter #(
  parameter int LIMIT = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic reached
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_tick;

  assign last_tick = run && tick && (cnt_q == CW'(LIMIT - 1));
  assign reached   = last_tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (tick && !last_tick)
      cnt_d = cnt_q + 1'b1;
    else if (last_tick)
      cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dcs_seq_fsm.sv
module dcs_seq_fsm
  import dcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wait_hit,
  output logic count_run,
  output logic capture,
  output logic apply,
  output logic mute,
  output logic busy,
  output logic done
);
  seq_state_t state_q, state_d;
  logic       mute_q, mute_d;

  assign capture   = (state_q == ST_IDLE) && start;
  assign apply     = (state_q == ST_APPLY);
  assign count_run = (state_q == ST_MUTE_WAIT) || (state_q == ST_SETTLE_WAIT);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_RELEASE);
  assign mute      = mute_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:        if (start)    state_d = ST_MUTE_WAIT;
      ST_MUTE_WAIT:   if (wait_hit) state_d = ST_APPLY;
      ST_APPLY:                     state_d = ST_SETTLE_WAIT;
      ST_SETTLE_WAIT: if (wait_hit) state_d = ST_RELEASE;
      ST_RELEASE:                   state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mute_d = mute_q;
    if (capture)                  mute_d = 1'b1;
    else if (state_q == ST_RELEASE) mute_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mute_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mute_q  <= mute_d;
    end
  end
endmodule

// File: rtl/dcs_cfg_hold.sv
module dcs_cfg_hold #(
  parameter int              DIV_W   = 4,
  parameter int              OSR_W   = 3,
  parameter logic [DIV_W-1:0] DEF_DIV = 4'd1,
  parameter logic [OSR_W-1:0] DEF_OSR = 3'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             apply,
  input  logic [DIV_W-1:0] req_div,
  input  logic [OSR_W-1:0] req_osr,
  output logic [DIV_W-1:0] cur_div,
  output logic [OSR_W-1:0] cur_osr
);
  localparam int CFG_W = DIV_W + OSR_W;

  logic [CFG_W-1:0] pend_q, pend_d;
  logic [CFG_W-1:0] cur_q, cur_d;

  always_comb begin
    pend_d = pend_q;
    if (capture) pend_d = {req_div, req_osr};
  end

  always_comb begin
    cur_d = cur_q;
    if (apply) cur_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= {DEF_DIV, DEF_OSR};
      cur_q  <= {DEF_DIV, DEF_OSR};
    end else begin
      pend_q <= pend_d;
      cur_q  <= cur_d;
    end
  end

  assign cur_div = cur_q[CFG_W-1:OSR_W];
  assign cur_osr = cur_q[OSR_W-1:0];
endmodule

// File: rtl/dcs_mute_gate.sv
module dcs_mute_gate #(
  parameter int CHANNELS = 2,
  parameter int CH_W     = 16
) (
  input  logic                     mute,
  input  logic [CHANNELS*CH_W-1:0] din,
  output logic [CHANNELS*CH_W-1:0] dout
);
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    assign dout[ch*CH_W +: CH_W] = mute ? '0 : din[ch*CH_W +: CH_W];
  end
endmodule

// File: rtl/dac_clkswitch_seq.sv
module dac_clkswitch_seq #(
  parameter int               CHANNELS     = 2,
  parameter int               CH_W         = 16,
  parameter int               DIV_W        = 4,
  parameter int               OSR_W        = 3,
  parameter int               SETTLE_TICKS = 300,
  parameter logic [DIV_W-1:0] DEF_DIV      = 4'd1,
  parameter logic [OSR_W-1:0] DEF_OSR      = 3'd2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fs_tick,
  input  logic [CHANNELS*CH_W-1:0] smp_in,
  input  logic                     start,
  input  logic [DIV_W-1:0]         req_div,
  input  logic [OSR_W-1:0]         req_osr,
  output logic                     busy,
  output logic                     done,
  output logic                     muted,
  output logic [CHANNELS*CH_W-1:0] smp_out,
  output logic [DIV_W-1:0]         cur_div,
  output logic [OSR_W-1:0]         cur_osr
);
  logic count_run, wait_hit, capture, apply, mute;

  dcs_tick_counter #(.LIMIT(SETTLE_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(count_run), .tick(fs_tick), .reached(wait_hit)
  );

  dcs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_hit(wait_hit),
    .count_run(count_run), .capture(capture), .apply(apply),
    .mute(mute), .busy(busy), .done(done)
  );

  dcs_cfg_hold #(
    .DIV_W(DIV_W), .OSR_W(OSR_W), .DEF_DIV(DEF_DIV), .DEF_OSR(DEF_OSR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(capture), .apply(apply),
    .req_div(req_div), .req_osr(req_osr), .cur_div(cur_div), .cur_osr(cur_osr)
  );

  dcs_mute_gate #(.CHANNELS(CHANNELS), .CH_W(CH_W)) u_gate (
    .mute(mute), .din(smp_in), .dout(smp_out)
  );

  assign muted = mute;
endmodule

// File: rtl/dac_clkswitch_seq_chk.sv
module dac_clkswitch_seq_chk #(
  parameter int CHANNELS     = 2,
  parameter int CH_W         = 16,
  parameter int DIV_W        = 4,
  parameter int OSR_W        = 3,
  parameter int SETTLE_TICKS = 300
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fs_tick,
  input logic                     start,
  input logic                     busy,
  input logic                     done,
  input logic                     muted,
  input logic [CHANNELS*CH_W-1:0] smp_out,
  input logic [DIV_W-1:0]         cur_div,
  input logic [OSR_W-1:0]         cur_osr
);
  logic [DIV_W+OSR_W-1:0] cfg, cfg_prev;
  logic [15:0]            since_mute, since_apply;

  assign cfg = {cur_div, cur_osr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_prev    <= '0;
      since_mute  <= '0;
      since_apply <= '0;
    end else begin
      cfg_prev <= cfg;
      if (!muted)                  since_mute <= '0;
      else if (since_mute != '1)   since_mute <= since_mute + 16'(fs_tick);
      if (cfg != cfg_prev)         since_apply <= 16'(fs_tick);
      else if (since_apply != '1)  since_apply <= since_apply + 16'(fs_tick);
    end
  end

  // R2
  zero_when_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    muted |-> (smp_out == '0));

  // R4
  cfg_change_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != $past(cfg)) |-> (muted && $past(muted)));

  // R4
  cfg_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != $past(cfg)) |-> (since_mute >= 16'(SETTLE_TICKS)));

  // R5
  release_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(muted) |-> (since_apply >= 16'(SETTLE_TICKS)));

  // R5
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !muted));

  // R3
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && muted));

  // R7
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !$rose(busy));
endmodule

bind dac_clkswitch_seq dac_clkswitch_seq_chk #(
  .CHANNELS(CHANNELS), .CH_W(CH_W), .DIV_W(DIV_W), .OSR_W(OSR_W),
  .SETTLE_TICKS(SETTLE_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .start(start), .busy(busy),
  .done(done), .muted(muted), .smp_out(smp_out), .cur_div(cur_div), .cur_osr(cur_osr)
);

// File: tb/dac_clkswitch_seq_bench.sv
module dac_clkswitch_seq_bench;
  localparam int CLK_P = 10;

  logic        clk, rst_n, fs_tick, start;
  logic [31:0] smp_in, smp_out;
  logic [3:0]  req_div, cur_div;
  logic [2:0]  req_osr, cur_osr;
  logic        busy, done, muted;
  int          checks, errs;

  dac_clkswitch_seq u_dac_clkswitch_seq (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .smp_in(smp_in), .start(start),
    .req_div(req_div), .req_osr(req_osr), .busy(busy), .done(done), .muted(muted),
    .smp_out(smp_out), .cur_div(cur_div), .cur_osr(cur_osr)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      fs_tick = 1'b1;
      @(negedge clk);
      fs_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(muted == 0, "R1 muted", muted, 0);
    chk(cur_div == 4'd1 && cur_osr == 3'd2, "R1 cfg", {cur_div, cur_osr}, {4'd1, 3'd2});
    smp_in = 32'hCAFE_0123;
    #1;
    chk(smp_out == smp_in, "R2 pass-through", smp_out, smp_in);
    ticks(5);
    chk(busy == 0 && muted == 0, "R8 idle ticks state", {busy, muted}, 0);
    chk(cur_div == 4'd1 && cur_osr == 3'd2, "R8 idle ticks cfg", {cur_div, cur_osr}, {4'd1, 3'd2});
  endtask

  task automatic t_full_sequence;
    smp_in = 32'h1234_5678; req_div = 4'd9; req_osr = 3'd5;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy == 1 && muted == 1, "R3 busy/muted after start", {busy, muted}, 2'b11);
    chk(smp_out == 0, "R2 muted output", smp_out, 0);
    req_div = 4'd3; req_osr = 3'd1;
    smp_in = 32'hFFFF_FFFF; #1;
    chk(smp_out == 0, "R2 muted all-ones input", smp_out, 0);
    ticks(10);
    req_div = 4'd6; req_osr = 3'd0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    ticks(289);
    chk(cur_div == 4'd1 && cur_osr == 3'd2, "R4 cfg held at 299 ticks", {cur_div, cur_osr}, {4'd1, 3'd2});
    ticks(1);
    chk(cur_div == 4'd9 && cur_osr == 3'd5, "R4 cfg applied (R7 late req ignored)", {cur_div, cur_osr}, {4'd9, 3'd5});
    chk(muted == 1, "R4 still muted at apply", muted, 1);
    ticks(299);
    chk(muted == 1 && busy == 1 && done == 0, "R5 held at 299 settle ticks", {muted, busy, done}, 3'b110);
    fs_tick = 1'b1; @(negedge clk); fs_tick = 1'b0;
    chk(done == 1 && muted == 1, "R5 done cycle", {done, muted}, 2'b11);
    @(negedge clk);
    chk(muted == 0 && busy == 0 && done == 0, "R5 released", {muted, busy, done}, 0);
    chk(smp_out == smp_in, "R2 output restored", smp_out, smp_in);
  endtask

  task automatic t_back_to_back;
    int n;
    req_div = 4'd2; req_osr = 3'd7;
    fs_tick = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 0;
    while (busy && n < 2000) begin
      if (done) begin start = 1'b1; req_div = 4'd15; req_osr = 3'd0; end
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == 602, "R6 busy length with held tick", n, 602);
    chk(busy == 0 && muted == 0, "R7 start in done cycle ignored", {busy, muted}, 0);
    chk(cur_div == 4'd2 && cur_osr == 3'd7, "R7 cfg from first request", {cur_div, cur_osr}, {4'd2, 3'd7});
    fs_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 0, "R7 stays idle", busy, 0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; errs = 0;
    rst_n = 1'b0; fs_tick = 1'b0; start = 1'b0;
    smp_in = '0; req_div = '0; req_osr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_sequence();
    t_back_to_back();
    finish_run();
  end
endmodule